// File: doc/BRIEF.md
# Windowed Interrupt Status Aggregator

This block gathers interrupt events from a USB device core and from a storage-bus controller. It presents them to a host through a small 8-bit register interface. Global USB events are held in a main status register. Each of four endpoints (0, a, b, c) has its own detailed status and enable register. These endpoint registers are not mapped directly. An index register steers them into two access windows: its upper nibble drives window 0 and its lower nibble drives window 1.

Summary bits sit above the detailed bits. The endpoint summary register holds one bit per endpoint. Main status bit 0 summarises the enabled endpoint summary bits. From the masked main status the block drives two active-low interrupt requests, one for USB events and one for the storage bus. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `irq_window_agg`

## Requirements
- R1: After reset every status and enable register reads 00h, the index register (08h) reads 01h, and both interrupt outputs are high.
- R2: A pulse on `main_evt_i[k]` sets main status (00h) bit k+1 at the next clock edge. The bit then stays set until it is cleared. The bit meanings from 7 down to 1 are: resume, bus reset, suspend, SOF seen, DMA done, storage-bus interrupt, SETUP received.
- R3: Writing 00h with a 1 in bit 7..1 clears that status bit, and a 0 leaves it unchanged. When an event and a clear hit the same bit in the same cycle, the event wins.
- R4: A pulse on `ep_evt_i[8*r+k]` sets bit k of endpoint r's detailed status. Writing 1s to the status window (02h or 03h) that currently shows endpoint r clears those bits, and the event wins on a same-cycle conflict.
- R5: Index bits 7:4 select the endpoint shown in status window 0 (02h) and enable window 0 (06h). Index bits 3:0 select the endpoint for status window 1 (03h) and enable window 1 (07h). Nibble values 0, 1, 2 and 3 select endpoints 0, a, b and c. The index changes only when 08h is written.
- R6: An index nibble above 3 makes its windows read 00h, and writes to those windows change nothing.
- R7: Endpoint summary (01h) bit r is the OR of endpoint r's status bits that are also enabled. Bits 7:4 read 0, and writes to 01h are ignored.
- R8: Main status bit 0 is set when any endpoint summary bit is set together with its bit in the summary enable register (05h, bits 3:0). Main enable (04h) is a plain 8-bit read/write register.
- R9: `irq_usb_n` is low exactly when some main status bit other than bit 2 is set together with its bit in 04h.
- R10: `irq_stor_n` is low exactly when main status bit 2 and 04h bit 2 are both set.
- R11: Addresses outside 00h..08h read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| main_evt_i | input | 7 | Global event pulses, bit k maps to main status bit k+1 |
| ep_evt_i | input | 32 | Endpoint event pulses, 8 bits per endpoint, endpoint 0 in the low byte |
| irq_usb_n | output | 1 | Active-low USB interrupt request |
| irq_stor_n | output | 1 | Active-low storage-bus interrupt request |

## Verification
Directed cases first steer both windows onto the same endpoint and then onto different endpoints. This shows whether each window follows its own nibble and whether nibble values above 3 are blocked. Cycles that raise an event and clear the same bit tell apart a design where the event wins from one where the clear wins. Sequences that set detailed bits while the enables stay zero, and then open each enable level in turn, show that every summary level applies its mask. Random cycles mix writes to every address, including unmapped ones, with sparse event pulses. They cover index values in all nibble combinations and follow the two interrupt outputs through the whole run.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int STOR_BIT = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_MAIN_ST = 6'h00,
    A_EP_SUM  = 6'h01,
    A_ST_WIN0 = 6'h02,
    A_ST_WIN1 = 6'h03,
    A_MAIN_EN = 6'h04,
    A_SUM_EN  = 6'h05,
    A_EN_WIN0 = 6'h06,
    A_EN_WIN1 = 6'h07,
    A_INDEX   = 6'h08
  } reg_addr_e;

  // sticky status: set by events, cleared by write-one, event wins
  function automatic logic [DATA_W-1:0] sticky_next(
      input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] set,
      input logic [DATA_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic nib_hits(input logic [NIB_W-1:0] nib, input int unsigned ep);
    return nib == ep[NIB_W-1:0];
  endfunction
endpackage

// File: rtl/irq_ep_bank.sv
module irq_ep_bank
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt,
  input  logic [DATA_W-1:0] clr,
  input  logic              en_we,
  input  logic [DATA_W-1:0] en_wdata,
  output logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] en,
  output logic              summary
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= sticky_next(stat, evt, clr);
      if (en_we) en <= en_wdata;
    end
  end

  assign summary = |(stat & en);
endmodule

// File: rtl/irq_main_regs.sv
module irq_main_regs
  import irq_agg_pkg::*;
#(
  parameter int          NUM_EP  = 4,
  parameter logic [7:0]  IDX_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-2:0] evt,
  input  logic [DATA_W-2:0] clr,
  input  logic              en_we,
  input  logic              sen_we,
  input  logic              idx_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-2:0] stat_hi,
  output logic [DATA_W-1:0] main_en,
  output logic [NUM_EP-1:0] sum_en,
  output logic [DATA_W-1:0] idx
);
  logic [DATA_W-1:0] nxt;
  assign nxt = sticky_next({stat_hi, 1'b0}, {evt, 1'b0}, {clr, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_hi <= '0;
      main_en <= '0;
      sum_en  <= '0;
      idx     <= IDX_RST;
    end else begin
      stat_hi <= nxt[DATA_W-1:1];
      if (en_we)  main_en <= wdata;
      if (sen_we) sum_en  <= wdata[NUM_EP-1:0];
      if (idx_we) idx     <= wdata;
    end
  end
endmodule

// File: rtl/irq_window_agg.sv
module irq_window_agg
  import irq_agg_pkg::*;
#(
  parameter int         NUM_EP  = 4,
  parameter logic [7:0] IDX_RST = 8'h01
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [DATA_W-2:0]        main_evt_i,
  input  logic [NUM_EP*DATA_W-1:0] ep_evt_i,
  output logic                     irq_usb_n,
  output logic                     irq_stor_n
);
  localparam logic [DATA_W-1:0] STOR_MASK = DATA_W'(1) << STOR_BIT;

  logic [DATA_W-1:0] idx, main_en, main_view;
  logic [DATA_W-2:0] main_hi;
  logic [NUM_EP-1:0] sum_en, ep_sum, hit0, hit1;
  logic [DATA_W-1:0] ep_stat [NUM_EP];
  logic [DATA_W-1:0] ep_en   [NUM_EP];
  logic [DATA_W-1:0] win_st0, win_st1, win_en0, win_en1;
  logic main_sum, usb_req, stor_req;

  // write strobes per address
  logic w_main, w_stw0, w_stw1, w_men, w_sen, w_enw0, w_enw1, w_idx;
  assign w_main = wr_en && addr == A_MAIN_ST;
  assign w_stw0 = wr_en && addr == A_ST_WIN0;
  assign w_stw1 = wr_en && addr == A_ST_WIN1;
  assign w_men  = wr_en && addr == A_MAIN_EN;
  assign w_sen  = wr_en && addr == A_SUM_EN;
  assign w_enw0 = wr_en && addr == A_EN_WIN0;
  assign w_enw1 = wr_en && addr == A_EN_WIN1;
  assign w_idx  = wr_en && addr == A_INDEX;

  irq_main_regs #(.NUM_EP(NUM_EP), .IDX_RST(IDX_RST)) u_main (
    .clk(clk), .rst_n(rst_n), .evt(main_evt_i),
    .clr(w_main ? wr_data[DATA_W-1:1] : '0),
    .en_we(w_men), .sen_we(w_sen), .idx_we(w_idx), .wdata(wr_data),
    .stat_hi(main_hi), .main_en(main_en), .sum_en(sum_en), .idx(idx)
  );

  for (genvar r = 0; r < NUM_EP; r++) begin : g_ep
    logic [DATA_W-1:0] clr_r;
    assign hit0[r] = nib_hits(idx[DATA_W-1:NIB_W], r);
    assign hit1[r] = nib_hits(idx[NIB_W-1:0], r);
    assign clr_r = ((w_stw0 && hit0[r]) ? wr_data : '0) |
                   ((w_stw1 && hit1[r]) ? wr_data : '0);
    irq_ep_bank u_bank (
      .clk(clk), .rst_n(rst_n), .evt(ep_evt_i[r*DATA_W +: DATA_W]),
      .clr(clr_r), .en_we((w_enw0 && hit0[r]) || (w_enw1 && hit1[r])),
      .en_wdata(wr_data), .stat(ep_stat[r]), .en(ep_en[r]), .summary(ep_sum[r])
    );
  end

  // window views: no hit (nibble out of range) reads zero
  always_comb begin
    win_st0 = '0; win_st1 = '0; win_en0 = '0; win_en1 = '0;
    for (int r = 0; r < NUM_EP; r++) begin
      if (hit0[r]) begin win_st0 = ep_stat[r]; win_en0 = ep_en[r]; end
      if (hit1[r]) begin win_st1 = ep_stat[r]; win_en1 = ep_en[r]; end
    end
  end

  assign main_sum  = |(ep_sum & sum_en);
  assign main_view = {main_hi, main_sum};
  assign usb_req   = |(main_view & main_en & ~STOR_MASK);
  assign stor_req  = |(main_view & main_en & STOR_MASK);
  assign irq_usb_n  = ~usb_req;
  assign irq_stor_n = ~stor_req;

  always_comb begin
    case (addr)
      A_MAIN_ST: rd_data = main_view;
      A_EP_SUM:  rd_data = DATA_W'(ep_sum);
      A_ST_WIN0: rd_data = win_st0;
      A_ST_WIN1: rd_data = win_st1;
      A_MAIN_EN: rd_data = main_en;
      A_SUM_EN:  rd_data = DATA_W'(sum_en);
      A_EN_WIN0: rd_data = win_en0;
      A_EN_WIN1: rd_data = win_en1;
      A_INDEX:   rd_data = idx;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_window_agg_chk.sv
module irq_window_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-2:0] wr_hi,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-2:0] main_evt_i,
  input logic [DATA_W-1:0] idx,
  input logic [DATA_W-2:0] main_hi,
  input logic [DATA_W-1:0] main_en,
  input logic              irq_usb_n,
  input logic              irq_stor_n
);
  p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (main_evt_i != '0) |=> ((main_hi & $past(main_evt_i)) == $past(main_evt_i)));

  p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MAIN_ST && main_evt_i == '0) |=> ((main_hi & $past(wr_hi)) == '0));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_MAIN_ST) |=> ((main_hi & $past(main_hi)) == $past(main_hi)));

  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_INDEX) |=> $stable(idx));

  p_bad_nib_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_ST_WIN0 && 32'(idx[7:4]) >= NUM_EP) |-> rd_data == '0);

  p_usb_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_usb_n |-> ((main_en & 8'hFB) != '0));

  p_stor_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_stor_n |-> (main_hi[STOR_BIT-1] && main_en[STOR_BIT]));
endmodule

bind irq_window_agg irq_window_agg_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_hi(wr_data[7:1]),
  .rd_data(rd_data), .main_evt_i(main_evt_i), .idx(idx), .main_hi(main_hi),
  .main_en(main_en), .irq_usb_n(irq_usb_n), .irq_stor_n(irq_stor_n)
);

// File: tb/irq_window_agg_bench.sv
module irq_window_agg_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] main_evt_i = 0;
  logic [31:0] ep_evt_i = 0;
  logic [7:0] rd_data;
  logic irq_usb_n, irq_stor_n;
  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_stat, m_en, m_idx;
  logic [3:0] m_sen;
  logic [7:0] m_est [4];
  logic [7:0] m_een [4];

  always #2 clk = ~clk;

  irq_window_agg u_irq_window_agg (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .main_evt_i(main_evt_i), .ep_evt_i(ep_evt_i),
    .irq_usb_n(irq_usb_n), .irq_stor_n(irq_stor_n));

  function automatic logic [3:0] m_sum();
    logic [3:0] s;
    for (int r = 0; r < 4; r++) s[r] = (m_est[r] & m_een[r]) != 0;
    return s;
  endfunction

  function automatic logic [7:0] m_main();
    return {m_stat[7:1], (m_sum() & m_sen) != 0};
  endfunction

  function automatic logic [7:0] m_win(input logic [3:0] nib, input bit en_side);
    if (nib > 3) return 8'h00;
    return en_side ? m_een[nib[1:0]] : m_est[nib[1:0]];
  endfunction

  function automatic logic [7:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_main();
      6'h01: return {4'h0, m_sum()};
      6'h02: return m_win(m_idx[7:4], 0);
      6'h03: return m_win(m_idx[3:0], 0);
      6'h04: return m_en;
      6'h05: return {4'h0, m_sen};
      6'h06: return m_win(m_idx[7:4], 1);
      6'h07: return m_win(m_idx[3:0], 1);
      6'h08: return m_idx;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_stat = 0; m_en = 0; m_idx = 8'h01; m_sen = 0;
    for (int r = 0; r < 4; r++) begin m_est[r] = 0; m_een[r] = 0; end
  endtask

  task automatic m_step(input bit w, input logic [5:0] a, input logic [7:0] d,
                        input logic [6:0] me, input logic [31:0] ee);
    logic [7:0] clr;
    logic [7:0] oidx;
    oidx = m_idx;
    if (w && a == 6'h00) m_stat[7:1] = m_stat[7:1] & ~d[7:1];
    m_stat[7:1] = m_stat[7:1] | me;
    m_stat[0] = 1'b0;
    for (int r = 0; r < 4; r++) begin
      clr = 0;
      if (w && a == 6'h02 && oidx[7:4] == r) clr = clr | d;
      if (w && a == 6'h03 && oidx[3:0] == r) clr = clr | d;
      m_est[r] = (m_est[r] & ~clr) | ee[r*8 +: 8];
      if (w && a == 6'h06 && oidx[7:4] == r) m_een[r] = d;
      if (w && a == 6'h07 && oidx[3:0] == r) m_een[r] = d;
    end
    if (w && a == 6'h04) m_en = d;
    if (w && a == 6'h05) m_sen = d[3:0];
    if (w && a == 6'h08) m_idx = d;
  endtask

  task automatic cyc(input bit w, input logic [5:0] a, input logic [7:0] d,
                     input logic [6:0] me, input logic [31:0] ee);
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d; main_evt_i = me; ep_evt_i = ee;
    @(posedge clk);
    m_step(w, a, d, me, ee);
  endtask

  task automatic chk(input logic [5:0] a, input string tag);
    logic [7:0] exp_rd;
    logic exp_u, exp_s, mm;
    @(negedge clk);
    wr_en = 0; main_evt_i = 0; ep_evt_i = 0; addr = a;
    #1;
    exp_rd = m_read(a);
    mm = 1'b0;
    exp_u = !((m_main() & m_en & 8'hFB) != 0);
    exp_s = !(m_main()[2] && m_en[2]);
    checks++;
    if (rd_data !== exp_rd) begin
      fails++; mm = 1'b1;
      $display("FAIL %s addr %0h: rd_data actual %0h expected %0h", tag, a, rd_data, exp_rd);
    end
    if (irq_usb_n !== exp_u) begin
      if (!mm) fails++;
      mm = 1'b1;
      $display("FAIL %s/R9 irq_usb_n actual %0b expected %0b", tag, irq_usb_n, exp_u);
    end
    if (irq_stor_n !== exp_s) begin
      if (!mm) fails++;
      $display("FAIL %s/R10 irq_stor_n actual %0b expected %0b", tag, irq_stor_n, exp_s);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(6'h08, "R1"); chk(6'h00, "R1"); chk(6'h02, "R1"); chk(6'h05, "R1");
    // R2 latch: resume event, then idle cycles keep it
    cyc(0, 0, 0, 7'h40, 0); cyc(0, 0, 0, 0, 0); chk(6'h00, "R2");
    // R3 clear and event-wins conflict
    cyc(1, 6'h00, 8'h80, 0, 0); chk(6'h00, "R3");
    cyc(0, 0, 0, 7'h01, 0);
    cyc(1, 6'h00, 8'h02, 7'h01, 0); chk(6'h00, "R3");
    cyc(1, 6'h00, 8'h00, 0, 0); chk(6'h00, "R3");
    // R9 enable SETUP bit
    cyc(1, 6'h04, 8'h02, 0, 0); chk(6'h04, "R9");
    // R10 storage-bus bit and its enable
    cyc(0, 0, 0, 7'h02, 0); chk(6'h00, "R10");
    cyc(1, 6'h04, 8'h04, 0, 0); chk(6'h00, "R10");
    cyc(1, 6'h00, 8'h06, 0, 0); chk(6'h00, "R10");
    // R4/R5 endpoint b event, windows steered by nibbles
    cyc(0, 0, 0, 0, 32'h0008_0000);
    cyc(1, 6'h08, 8'h20, 0, 0); chk(6'h02, "R5"); chk(6'h03, "R5");
    chk(6'h01, "R7");
    cyc(1, 6'h08, 8'h22, 0, 0);
    cyc(1, 6'h07, 8'h08, 0, 0); chk(6'h06, "R5"); chk(6'h01, "R7");
    cyc(1, 6'h01, 8'hFF, 0, 0); chk(6'h01, "R7");
    cyc(1, 6'h05, 8'h04, 0, 0); chk(6'h00, "R8");
    cyc(1, 6'h04, 8'h01, 0, 0); chk(6'h00, "R8");
    // R4 clear through window 1, then conflict through window 0
    cyc(1, 6'h03, 8'h08, 0, 0); chk(6'h02, "R4"); chk(6'h00, "R4");
    cyc(1, 6'h02, 8'h10, 0, 32'h0010_0000); chk(6'h03, "R4");
    // R6 out-of-range nibbles
    cyc(1, 6'h08, 8'h5F, 0, 0); chk(6'h02, "R6"); chk(6'h03, "R6"); chk(6'h06, "R6");
    cyc(1, 6'h06, 8'hFF, 0, 0); cyc(1, 6'h03, 8'hFF, 0, 0);
    cyc(1, 6'h08, 8'h02, 0, 0); chk(6'h06, "R6"); chk(6'h07, "R6"); chk(6'h03, "R6");
    // R11 unmapped
    cyc(1, 6'h2A, 8'hFF, 0, 0); chk(6'h2A, "R11"); chk(6'h0C, "R11");
    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [5:0] a;
      logic [7:0] d;
      a = ($urandom % 8 == 0) ? 6'($urandom) : 6'($urandom % 9);
      d = 8'($urandom);
      if (a == 6'h08 && ($urandom % 4 != 0)) d = d & 8'h33;
      cyc(($urandom % 3) != 0, a, d, 7'($urandom & $urandom & $urandom),
          $urandom & $urandom & $urandom & $urandom);
      chk(6'($urandom % 10), "R2-random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule